// File: doc/BRIEF.md
# Asynchronous SRAM Read/Write Controller

This block sits between a clocked request port and an external asynchronous static RAM of 128K bytes. A requester presents a read or write with an address, and write data for a write, under a valid/ready handshake. The controller then drives the active-low chip-select, output-enable and write-strobe pins and the 17-bit address. It drives the data pins through a separate output-enable, because the data bus is shared with the memory. Read data returns on a response port that is valid for one cycle.

The number of wait cycles is not typed in by hand. It comes from the clock period and from the memory's speed-grade timing, all given as parameters in nanoseconds. The read hold length is the ceiling of the slower of the address-to-data and enable-to-data access times over the clock period. The write-strobe width uses the same count. The idle gap after a read is the ceiling of the pin float time over the clock period, and it is at least one cycle.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, all three memory strobes (chip select, output enable, write strobe) are high, the data-pin output enable is low, the response valid is low and the request ready is high.
- R2: A request is taken on a clock edge where both valid and ready are high. Ready stays low from that edge until the whole operation, including any turnaround gap, has finished.
- R3: A read holds chip select low, output enable low and write strobe high, with the requested address on the pins, for RD_WAIT cycles. RD_WAIT = max(ceil(tAA/tCLK), ceil(tOE/tCLK)). The data pins are sampled at the clock edge that ends the last of those cycles.
- R4: Read data appears on the response port with a one-cycle valid pulse in the cycle right after the last read cycle. The response data keeps its value after the pulse.
- R5: A write is one setup cycle (chip select low, data driven, write strobe high), then WR_WAIT = RD_WAIT cycles with the write strobe low, then one hold cycle with the write strobe high and data still driven. The address stays constant throughout, and ready returns WR_WAIT+3 cycles after the accepting edge.
- R6: The controller drives the data pins only while it performs a write, and never while output enable is low.
- R7: After a read, all strobes are released for HZ_GAP = max(1, ceil(tHZ/tCLK)) cycles before the next request can be taken, so the memory's outputs float before the controller drives the bus.
- R8: A byte written to an address is returned by a later read of that address, including the lowest address 0x00000 and the highest 0x1FFFF. A later write to the same address replaces the byte.
- R9: While no request is pending, the memory is deselected: all strobes are high and the data pins are not driven.
- R10: Changes on the request address or data while an operation is in progress have no effect on the memory address pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle read-data valid |
| rspRdata | output | 8 | Read data |
| memAddr | output | 17 | Memory address pins |
| memCeN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqOe | output | 1 | Drive enable for the data pins |
| memDqIn | input | 8 | Data received from the memory |

## Verification
The vector walk mixes several kinds of traffic: writes at the lowest, highest and a middle address; reads of those addresses; an overwrite issued right after a read; and a read of an address never written. This tells apart wrong data, address aliasing at the range ends, a missing read-to-write turnaround and a stale response. The bench memory model only delivers valid data once the address and strobes have been steady for the access time. It also keeps driving for the float time after output enable is released. A shortened read count therefore shows up as a wrong byte, and a missing gap shows up as bus contention. Directed tests cover the idle state, the reset values and changes on the request port during a read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctlStateT;

  // pin-level strobes, all registered in the control block
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic dqOe;
  } pinStrobeT;

  // everything the control hands to the datapath
  typedef struct packed {
    logic      load;
    logic      capture;
    pinStrobeT pins;
  } ctlStrobeT;

  function automatic int ceilDiv(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_WAIT = 1,
  parameter int WR_WAIT = 1,
  parameter int HZ_GAP  = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output ctlStrobeT ctl
);

  localparam int CNT_MAX = maxOf(maxOf(RD_WAIT, WR_WAIT), HZ_GAP);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam pinStrobeT PINS_IDLE = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, dqOe: 1'b0};
  localparam pinStrobeT PINS_READ = '{ceN: 1'b0, oeN: 1'b0, weN: 1'b1, dqOe: 1'b0};
  localparam pinStrobeT PINS_WDAT = '{ceN: 1'b0, oeN: 1'b1, weN: 1'b1, dqOe: 1'b1};
  localparam pinStrobeT PINS_WSTB = '{ceN: 1'b0, oeN: 1'b1, weN: 1'b0, dqOe: 1'b1};

  ctlStateT   st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  pinStrobeT  pinsQ;
  logic       load, capture;

  function automatic pinStrobeT decodePins(ctlStateT s);
    case (s)
      ST_READ:             return PINS_READ;
      ST_WSETUP, ST_WHOLD: return PINS_WDAT;
      ST_WPULSE:           return PINS_WSTB;
      default:             return PINS_IDLE;
    endcase
  endfunction

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    load    = 1'b0;
    capture = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (reqValid) begin
          load = 1'b1;
          if (reqWrite) begin
            stNext = ST_WSETUP;
          end else begin
            stNext  = ST_READ;
            cntNext = CNT_W'(RD_WAIT - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          capture = 1'b1;
          stNext  = ST_TURN;
          cntNext = CNT_W'(HZ_GAP - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) stNext = ST_IDLE;
        else           cntNext = cnt - 1'b1;
      end
      ST_WSETUP: begin
        stNext  = ST_WPULSE;
        cntNext = CNT_W'(WR_WAIT - 1);
      end
      ST_WPULSE: begin
        if (cnt == '0) stNext = ST_WHOLD;
        else           cntNext = cnt - 1'b1;
      end
      ST_WHOLD: stNext = ST_IDLE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      pinsQ <= PINS_IDLE;
    end else begin
      st    <= stNext;
      cnt   <= cntNext;
      pinsQ <= decodePins(stNext);
    end
  end

  assign reqReady = (st == ST_IDLE);

  always_comb begin
    ctl.load    = load;
    ctl.capture = capture;
    ctl.pins    = pinsQ;
  end

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= ctl.capture;
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memCeN   = ctl.pins.ceN;
  assign memOeN   = ctl.pins.oeN;
  assign memWeN   = ctl.pins.weN;
  assign memDqOe  = ctl.pins.dqOe;
  assign rspValid = rspQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 10,
  parameter int T_OE_NS = 5,
  parameter int T_HZ_NS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_WAIT = maxOf(1, maxOf(ceilDiv(T_AA_NS, CLK_NS), ceilDiv(T_OE_NS, CLK_NS)));
  localparam int WR_WAIT = RD_WAIT;
  localparam int HZ_GAP  = maxOf(1, ceilDiv(T_HZ_NS, CLK_NS));

  ctlStrobeT ctl;

  sram_ctl_fsm #(
    .RD_WAIT(RD_WAIT),
    .WR_WAIT(WR_WAIT),
    .HZ_GAP (HZ_GAP)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOe (memDqOe),
    .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDqOe
);

  assert_idle_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memOeN && memWeN && !memDqOe));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);

  assert_strobe_with_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe && !memCeN && memOeN));

  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $past(memDqOe));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && $stable(memAddr)));

  assert_addr_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> !reqReady);

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!memOeN));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .memWeN  (memWeN),
  .memDqOe (memDqOe)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

  localparam int CLK = 10;
  localparam int TAA = 15;
  localparam int TOE = 7;
  localparam int THZ = 7;
  // expected counts worked out from the requirements
  localparam int EXP_RD  = 2;  // max(ceil(15/10), ceil(7/10))
  localparam int EXP_WR  = 2;
  localparam int EXP_GAP = 1;  // ceil(7/10)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspRdata, memDqOut, memDqIn;
  logic [16:0] memAddr;
  logic        memCeN, memOeN, memWeN, memDqOe;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  sram_ctl #(.CLK_NS(CLK), .T_AA_NS(TAA), .T_OE_NS(TOE), .T_HZ_NS(THZ)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model, updated between edges ----------------
  logic [7:0]  modelMem [int];
  logic [19:0] pinsPrev = '1;
  int          stableCnt = 0, relIdx = 1000;
  logic        prevWeN = 1'b1, prevDqOe = 1'b0;
  logic        modelDrive = 1'b0;
  logic [7:0]  modelData = 8'hEE;

  assign memDqIn = modelDrive ? modelData : 8'hEE;

  always @(negedge clk) begin
    logic [19:0] pinsNow;
    logic        readAct;
    pinsNow = {memAddr, memCeN, memOeN, memWeN};
    readAct = !memCeN && !memOeN && memWeN;
    if (pinsNow != pinsPrev) stableCnt = 0; else stableCnt++;
    if (readAct) relIdx = -1; else if (relIdx < 1000) relIdx++;
    modelDrive = readAct || (relIdx * CLK < THZ);
    if (readAct && ((stableCnt + 1) * CLK >= TAA))
      modelData = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : 8'h00;
    else
      modelData = 8'hEE;
    if (rstN) begin
      if (modelDrive && memDqOe) check("R6 bus contention", 1, 0);
      if (!memWeN && memCeN) check("R5 strobe while deselected", 1, 0);
      if (prevWeN && !memWeN && !prevDqOe) check("R5 data setup before strobe", 0, 1);
      if (!prevWeN && !memWeN && pinsNow[19:3] != pinsPrev[19:3]) check("R5 address moved in strobe", 1, 0);
      if (!prevWeN && memWeN) begin
        if (!memDqOe) check("R5 data hold after strobe", 0, 1);
        modelMem[int'(memAddr)] = memDqOut;
      end
    end
    pinsPrev = pinsNow;
    prevWeN  = memWeN;
    prevDqOe = memDqOe;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- operations ----------------
  task automatic doWrite(input logic [16:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    n = 1;
    while (!reqReady && n < 100) begin @(negedge clk); n++; end
    check("R5 write length", n, EXP_WR + 3);
  endtask

  task automatic doRead(input logic [16:0] a, input logic [7:0] exp);
    int n;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    n = 1;
    while (!rspValid && n < 100) begin @(negedge clk); n++; end
    check("R4 read latency", n, EXP_RD + 1);
    check("R3 R8 read data", rspRdata, exp);
    check("R7 ready low in gap", reqReady, 0);
    check("R7 strobes released", {memCeN, memOeN, memWeN, memDqOe}, 4'b1110);
    for (int g = 1; g < EXP_GAP; g++) @(negedge clk);
    @(negedge clk);
    check("R4 pulse one cycle", rspValid, 0);
    check("R4 data held", rspRdata, exp);
    check("R7 ready after gap", reqReady, 1);
  endtask

  // {write, addr, wdata, expected}
  localparam logic [33:0] VEC [9] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
    {1'b1, 17'h0F0F0, 8'h3C, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
    {1'b1, 17'h00000, 8'hFF, 8'h00},
    {1'b0, 17'h0F0F0, 8'h00, 8'h3C},
    {1'b0, 17'h00000, 8'h00, 8'hFF},
    {1'b0, 17'h12345, 8'h00, 8'h00}
  };

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", {memCeN, memOeN, memWeN, memDqOe}, 4'b1110);
    check("R1 rsp valid in reset", rspValid, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 ready after reset", reqReady, 1);
    check("R1 strobes after reset", {memCeN, memOeN, memWeN, memDqOe}, 4'b1110);

    // main vector walk (R8 across address extremes and overwrite)
    foreach (VEC[i]) begin
      if (VEC[i][33]) doWrite(VEC[i][32:16], VEC[i][15:8]);
      else            doRead(VEC[i][32:16], VEC[i][7:0]);
    end

    // R9: idle keeps the memory deselected
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 idle deselect", {memCeN, memOeN, memWeN, memDqOe}, 4'b1110);
    end

    // R10 and R2: request port changes during a read are ignored
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 17'h1FFFF;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0; reqAddr = 17'h00001; reqWdata = 8'h77;
    check("R10 address kept", memAddr, 17'h1FFFF);
    check("R2 ready low while busy", reqReady, 0);
    @(negedge clk);
    check("R10 address kept later", memAddr, 17'h1FFFF);
    check("R3 read strobes", {memCeN, memOeN, memWeN, memDqOe}, 4'b0010);
    @(negedge clk);
    check("R4 rsp after hold", rspValid, 1);
    check("R10 read data unaffected", rspRdata, 8'h5A);
    @(negedge clk);
    check("R2 ready back", reqReady, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule